// File: doc/BRIEF.md
# Hierarchical Priority-Encoder Hit Readout

This block holds a column pair of 1024 single-bit hit flags and reads them out zero-suppressed. It does not scan all 1024 positions. A tree of identical four-input arbiter units finds the occupied flags. Each unit ORs its four inputs into a "something is set" signal and reports which of its inputs won. The winner is the lowest-numbered active input. The 2-bit local codes of the five levels are joined into a 10-bit flag address. The same tree carries a clear request downward and delivers it only to the leaf that is currently winning. That leaf is the one whose address is being reported.

A sequencer at the top of the tree drives the readout. After a start request it takes the winning address, publishes it with a one-cycle valid strobe, and sends the clear down the tree for one cycle. It samples the tree again only after the clear has been released. The loop ends when the top of the tree shows nothing set, and a done flag is then raised. A readout of H hits therefore lasts 2H+1 cycles, so an empty column costs almost nothing.

Hit flags are loaded from a parallel hit vector under a strobe. This is only accepted while no readout is running. All sizes follow from one parameter, the number of tree levels.

Top module: `hier_pe_readout`

## Requirements
- R1: Synchronous active-high reset leaves `rd_valid` and `done` low and all hit flags cleared. A readout started right after reset reports no address.
- R2: While no readout is running, a clock edge with `strobe` high sets every flag whose `hit_in` bit is 1. Flags already set stay set, so successive strobes accumulate as a bitwise OR.
- R3: A readout reports each set flag exactly once. The reported `rd_addr` is the flag's bit index in `hit_in`. Reports come in strictly ascending address order because input 0 of every unit has the highest priority. The top level supplies address bits [9:8] and the leaf level supplies bits [1:0].
- R4: `rd_valid` is a one-cycle pulse and is never high in two consecutive cycles. A flag is cleared only in the cycle in which its address is on the output with `rd_valid` high.
- R5: Take a `start` accepted at clock edge E0 when H flags are set. `done` goes high after edge E0+2H+1 and stays high until the next accepted `start`, which clears it. `rd_valid` is low whenever `done` is high.
- R6: When a readout completes, all flags are clear. A second readout with no new strobe reports no address and finishes after one cycle.
- R7: `strobe` asserted while a readout is running has no effect. The offered bits are neither reported in that readout nor in a later one.
- R8: `start` asserted while a readout is running is ignored. The readout order and its length are unchanged.
- R9: At full occupancy, all 1024 flags are reported, from address 0 through address 1023, in 2049 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| strobe | input | 1 | Load enable for the hit vector (accepted only while idle) |
| hit_in | input | 1024 | Hit vector; bit i sets flag i |
| start | input | 1 | Begin a readout (accepted only while idle) |
| rd_addr | output | 10 | Address of the reported flag |
| rd_valid | output | 1 | One-cycle strobe qualifying `rd_addr` |
| done | output | 1 | Readout finished; held until the next start |

## Verification
The ordering check assumes that no strobe changes the flags between two reports of one readout. That property holds only because the design ignores strobes while busy. The bench still exercises the case by injecting strobes and starts mid-readout and checking at the ports that nothing changed. The one-hot check on the downward clear lines assumes the tree inputs are stable in the clear cycle. The bench keeps this by changing `hit_in` and `strobe` only on falling edges, with `strobe` low during every readout except in the deliberate R7 case.

// File: rtl/hpe_pkg.sv
`timescale 1ns/1ps
package hpe_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE   = 2'd0,
    SEQ_SAMPLE = 2'd1,
    SEQ_CLEAR  = 2'd2
  } seq_state_t;

  // Number of arbiter units in all levels below 'lvl' (level 0 = leaf units).
  function automatic int units_below(input int lvl, input int levels);
    int acc;
    acc = 0;
    for (int k = 0; k < lvl; k++) begin
      acc += 4 ** (levels - 1 - k);
    end
    return acc;
  endfunction

endpackage

// File: rtl/hpe_unit.sv
`timescale 1ns/1ps
module hpe_unit (
  input  logic [3:0] req_i,
  input  logic       clr_i,
  output logic       any_o,
  output logic [1:0] sel_o,
  output logic [3:0] clr_o
);

  // Lowest index wins.
  always_comb begin
    sel_o = 2'd0;
    for (int j = 3; j >= 0; j--) begin
      if (req_i[j]) sel_o = 2'(j);
    end
  end

  assign any_o = |req_i;

  // Clear is steered only to the winning input.
  always_comb begin
    clr_o = 4'b0000;
    if (clr_i && any_o) clr_o[sel_o] = 1'b1;
  end

endmodule

// File: rtl/hpe_tree.sv
`timescale 1ns/1ps
module hpe_tree #(
  parameter int LEVELS = 5,
  localparam int N     = 4 ** LEVELS,
  localparam int ABITS = 2 * LEVELS
) (
  input  logic [N-1:0]     state_i,
  input  logic             clr_i,
  output logic             any_o,
  output logic [ABITS-1:0] addr_o,
  output logic [N-1:0]     clr_leaf_o
);
  import hpe_pkg::*;

  localparam int TOT = (N - 1) / 3;

  logic [TOT-1:0]       node_any;
  logic [TOT*ABITS-1:0] node_addr;
  logic [TOT*4-1:0]     node_clr;

  for (genvar k = 0; k < LEVELS; k++) begin : g_lvl
    localparam int NU     = 4 ** (LEVELS - 1 - k);
    localparam int OFF    = units_below(k, LEVELS);
    localparam int CH_OFF = (k == 0) ? 0 : units_below(k - 1, LEVELS);
    localparam int PA_OFF = units_below(k + 1, LEVELS);

    for (genvar u = 0; u < NU; u++) begin : g_unit
      logic [3:0]       req;
      logic [1:0]       sel;
      logic             cin;
      logic [ABITS-1:0] an;

      if (k == 0) begin : g_leaf_in
        assign req = state_i[4*u +: 4];
        assign an  = ABITS'(sel);
      end else begin : g_node_in
        assign req = node_any[CH_OFF + 4*u +: 4];
        always_comb begin
          an = node_addr[(CH_OFF + 4*u + int'(sel)) * ABITS +: ABITS]
               | (ABITS'(sel) << (2 * k));
        end
      end

      if (k == LEVELS - 1) begin : g_root_clr
        assign cin = clr_i;
      end else begin : g_sub_clr
        assign cin = node_clr[PA_OFF * 4 + u];
      end

      hpe_unit u_unit (
        .req_i (req),
        .clr_i (cin),
        .any_o (node_any[OFF + u]),
        .sel_o (sel),
        .clr_o (node_clr[(OFF + u) * 4 +: 4])
      );

      assign node_addr[(OFF + u) * ABITS +: ABITS] = an;
    end
  end

  assign any_o      = node_any[TOT-1];
  assign addr_o     = node_addr[(TOT-1) * ABITS +: ABITS];
  assign clr_leaf_o = node_clr[N-1:0];

endmodule

// File: rtl/hpe_hits.sv
`timescale 1ns/1ps
module hpe_hits #(
  parameter int N = 1024
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic [N-1:0] hit_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] state_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_o <= '0;
    end else begin
      state_o <= (state_o & ~clr_i) | ({N{load_i}} & hit_i);
    end
  end

endmodule

// File: rtl/hpe_seq.sv
`timescale 1ns/1ps
module hpe_seq #(
  parameter int ABITS = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             any_i,
  input  logic [ABITS-1:0] addr_i,
  output logic             clr_o,
  output logic             accept_o,
  output logic [ABITS-1:0] addr_o,
  output logic             valid_o,
  output logic             done_o
);
  import hpe_pkg::*;

  seq_state_t st;

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= SEQ_IDLE;
      clr_o   <= 1'b0;
      valid_o <= 1'b0;
      addr_o  <= '0;
      done_o  <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      clr_o   <= 1'b0;
      case (st)
        SEQ_IDLE: begin
          if (start_i) begin
            st     <= SEQ_SAMPLE;
            done_o <= 1'b0;
          end
        end
        SEQ_SAMPLE: begin
          if (any_i) begin
            addr_o  <= addr_i;
            valid_o <= 1'b1;
            clr_o   <= 1'b1;
            st      <= SEQ_CLEAR;
          end else begin
            done_o <= 1'b1;
            st     <= SEQ_IDLE;
          end
        end
        SEQ_CLEAR: st <= SEQ_SAMPLE;
        default:   st <= SEQ_IDLE;
      endcase
    end
  end

  assign accept_o = (st == SEQ_IDLE);

endmodule

// File: rtl/hier_pe_readout.sv
`timescale 1ns/1ps
module hier_pe_readout #(
  parameter int LEVELS = 5,
  localparam int N     = 4 ** LEVELS,
  localparam int ABITS = 2 * LEVELS
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             strobe,
  input  logic [N-1:0]     hit_in,
  input  logic             start,
  output logic [ABITS-1:0] rd_addr,
  output logic             rd_valid,
  output logic             done
);

  logic [N-1:0]     flags;
  logic [N-1:0]     leaf_clr;
  logic             top_any;
  logic [ABITS-1:0] top_addr;
  logic             clr_top;
  logic             idle;

  hpe_hits #(.N(N)) u_hits (
    .clk     (clk),
    .rst     (rst),
    .load_i  (strobe & idle),
    .hit_i   (hit_in),
    .clr_i   (leaf_clr),
    .state_o (flags)
  );

  hpe_tree #(.LEVELS(LEVELS)) u_tree (
    .state_i    (flags),
    .clr_i      (clr_top),
    .any_o      (top_any),
    .addr_o     (top_addr),
    .clr_leaf_o (leaf_clr)
  );

  hpe_seq #(.ABITS(ABITS)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .start_i  (start),
    .any_i    (top_any),
    .addr_i   (top_addr),
    .clr_o    (clr_top),
    .accept_o (idle),
    .addr_o   (rd_addr),
    .valid_o  (rd_valid),
    .done_o   (done)
  );

endmodule

// File: rtl/hpe_readout_chk.sv
`timescale 1ns/1ps
module hpe_readout_chk #(
  parameter int N     = 1024,
  parameter int ABITS = 10
) (
  input logic             clk,
  input logic             rst,
  input logic             rd_valid,
  input logic [ABITS-1:0] rd_addr,
  input logic             done,
  input logic [N-1:0]     leaf_clr
);

  logic             have_prev;
  logic [ABITS-1:0] prev_addr;

  always_ff @(posedge clk) begin
    if (rst || done) begin
      have_prev <= 1'b0;
      prev_addr <= '0;
    end else if (rd_valid) begin
      have_prev <= 1'b1;
      prev_addr <= rd_addr;
    end
  end

  assert_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> !rd_valid);

  assert_clr_with_report_R4: assert property (@(posedge clk) disable iff (rst)
    (|leaf_clr) |-> rd_valid);

  assert_ascending_R3: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && have_prev) |-> (rd_addr > prev_addr));

  assert_single_clear_R3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(leaf_clr));

  assert_done_quiet_R5: assert property (@(posedge clk) disable iff (rst)
    done |-> !rd_valid);

endmodule

bind hier_pe_readout hpe_readout_chk #(.N(N), .ABITS(ABITS)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .rd_valid (rd_valid),
  .rd_addr  (rd_addr),
  .done     (done),
  .leaf_clr (leaf_clr)
);

// File: tb/sim_hier_pe_readout.sv
`timescale 1ns/1ps
module sim_hier_pe_readout;
  localparam int LEVELS = 5;
  localparam int N      = 4 ** LEVELS;
  localparam int ABITS  = 2 * LEVELS;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             strobe = 1'b0;
  logic [N-1:0]     hit_in = '0;
  logic             start = 1'b0;
  logic [ABITS-1:0] rd_addr;
  logic             rd_valid;
  logic             done;

  int compared   = 0;
  int mismatched = 0;
  bit finished   = 0;
  logic [N-1:0] model = '0;

  always #2 clk = ~clk;

  hier_pe_readout #(.LEVELS(LEVELS)) u0 (
    .clk(clk), .rst(rst), .strobe(strobe), .hit_in(hit_in),
    .start(start), .rd_addr(rd_addr), .rd_valid(rd_valid), .done(done)
  );

  task automatic check(input string req, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic load(input logic [N-1:0] v);
    @(negedge clk); strobe = 1'b1; hit_in = v;
    @(negedge clk); strobe = 1'b0; hit_in = '0;
    model = model | v;
  endtask

  // Runs one readout; optionally injects strobe/start at cycle inj_cyc.
  task automatic readout(input string req, input int inj_cyc,
                         input logic [N-1:0] inj_hits, input bit inj_start);
    int h, nxt, got, cyc;
    bit prev_v, fin, dbl;
    logic [N-1:0] expv;
    expv = model;
    h = $countones(expv);
    nxt = 0; got = 0; cyc = 0; prev_v = 0; fin = 0; dbl = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    while (!fin && cyc < 4*N + 16) begin
      if (cyc == inj_cyc) begin
        strobe = |inj_hits; hit_in = inj_hits; start = inj_start;
      end
      @(negedge clk);
      strobe = 1'b0; hit_in = '0; start = 1'b0;
      cyc++;
      if (rd_valid) begin
        if (prev_v) dbl = 1;
        while (nxt < N && !expv[nxt]) nxt++;
        check({req, " R3 address"}, int'(rd_addr), nxt);
        nxt++; got++;
      end
      prev_v = rd_valid;
      if (done) fin = 1;
    end
    check({req, " R4 back-to-back valid"}, int'(dbl), 0);
    check({req, " R5 done reached"}, int'(fin), 1);
    check({req, " R3 report count"}, got, h);
    check({req, " R5 cycles to done"}, cyc, 2*h + 1);
    @(negedge clk);
    check({req, " R5 done held"}, int'(done), 1);
    model = '0;
  endtask

  function automatic logic [N-1:0] rand_vec(input int pct);
    logic [N-1:0] v;
    for (int i = 0; i < N; i++) v[i] = (($urandom % 100) < pct);
    return v;
  endfunction

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 valid after reset", int'(rd_valid), 0);
    check("R1 done after reset", int'(done), 0);
    readout("R1 empty after reset", -1, '0, 0);
  endtask

  task automatic t_edges;
    logic [N-1:0] v;
    v = '0; v[0] = 1; v[N-1] = 1; v[511] = 1; v[2] = 1; v[1] = 1; v[256] = 1;
    load(v);
    readout("R9 edge addresses", -1, '0, 0);
  endtask

  task automatic t_random(input int pct);
    load(rand_vec(pct));
    readout("R3 random", -1, '0, 0);
    readout("R6 drained", -1, '0, 0);
  endtask

  task automatic t_accum;
    logic [N-1:0] a, b;
    a = rand_vec(3); b = rand_vec(3);
    load(a); load(b);
    readout("R2 accumulate", -1, '0, 0);
  endtask

  task automatic t_busy_strobe;
    logic [N-1:0] v, inj;
    v = '0; v[3] = 1; v[40] = 1; v[77] = 1;
    inj = '0; inj[900] = 1; inj[5] = 1;
    load(v);
    readout("R7 strobe while busy", 2, inj, 0);
    readout("R7 nothing latched", -1, '0, 0);
  endtask

  task automatic t_busy_start;
    logic [N-1:0] v;
    v = '0; v[10] = 1; v[600] = 1; v[601] = 1;
    load(v);
    readout("R8 start while busy", 2, '0, 1);
  endtask

  task automatic t_full;
    load('1);
    readout("R9 full occupancy", -1, '0, 0);
  endtask

  initial begin
    void'($urandom(32'h5eed));
    t_reset();
    t_edges();
    t_random(1);
    t_random(10);
    t_random(40);
    t_accum();
    t_busy_strobe();
    t_busy_start();
    t_full();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    #(4 * 190000);
    if (!finished) begin
      finished = 1;
      compared++; mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule